// File: doc/BRIEF.md
# Software-Refilled Instruction TLB

This block translates instruction fetch addresses through a small two-way set-associative buffer and leaves every refill to software. A fetch presents a 32-bit effective address together with the segment's 24-bit virtual segment identifier. Address bits 16..12 choose one of 32 sets. Both ways of that set are compared against a tag made of the segment identifier and address bits 27..17. A hit returns the 20-bit physical page number and two protection bits in the same cycle.

There is no table walker. On a miss the block freezes a miss context for a handler and raises a one-cycle exception pulse. That context holds the faulting address, the compare word for the sought page-table entry, and pointers to the primary and secondary entry groups. The block then stalls all fetches. Software searches both groups itself and installs the match with a load-entry command. That command carries the address operand (which selects the set), the compare word (which gives the tag) and a physical word (which gives the page number and protection). A global invalidate empties the buffer and drops any pending miss in one cycle.

Top module: `itlb_swfill`

## Requirements
- R1: A lookup hits in the same cycle when a valid way of set EA[16:12] holds tag {vsid, EA[27:17]}; lk_hit is 1, lk_stall is 0, and lk_ppn and lk_pp give that way's page number and protection bits.
- R2: A lookup that misses, with no miss pending and no load or invalidate in that cycle, drives lk_stall high. At the next edge it sets miss_pend, stores EA in the address register (read select 0), and pulses miss_irq high for exactly one cycle.
- R3: The compare register (read select 1) captured on a miss holds {1, vsid[23:0], 0, EA[27:22]}, MSB first.
- R4: With h = vsid[18:0] XOR {000, EA[27:12]}, the primary pointer (read select 2) captured on a miss is pt_base OR (h << 6). The secondary pointer (read select 3) is pt_base OR ((~h) << 6), where ~h is 19 bits wide.
- R5: While miss_pend is 1, every lookup gives lk_stall=1 and lk_hit=0, even for resident translations. The four miss registers keep their values, and miss_irq stays 0.
- R6: A load-entry command (ld_valid) writes set ld_rb[16:12]. The tag is {ld_cmp[30:7], ld_rb[27:17]}, the page number is ld_rpa[31:12] and the protection bits are ld_rpa[1:0]. From the next cycle miss_pend is 0 and a retried lookup hits.
- R7: A load fills way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the way named by the set's replacement bit. After a hit or a load, that bit names the other way.
- R8: inv_all clears every valid bit and miss_pend at the next edge. A load issued in the same cycle is dropped.
- R9: After reset no entry is valid, miss_pend and miss_irq are 0, and all four miss registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Invalidate all entries and drop a pending miss |
| pt_base | input | 32 | Page-table base ORed into both group pointers |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Fetch effective address |
| lk_vsid | input | 24 | Segment identifier for the fetch |
| lk_hit | output | 1 | Translation found |
| lk_stall | output | 1 | Lookup not served (miss or pending miss) |
| lk_ppn | output | 20 | Physical page number on a hit |
| lk_pp | output | 2 | Protection bits on a hit |
| miss_pend | output | 1 | Miss context held, waiting for refill |
| miss_irq | output | 1 | One-cycle miss exception pulse |
| rd_sel | input | 2 | Miss register select: 0 address, 1 compare, 2 primary, 3 secondary |
| rd_data | output | 32 | Selected miss register |
| ld_valid | input | 1 | Load-entry command |
| ld_rb | input | 32 | Address operand of the load-entry command |
| ld_cmp | input | 32 | Compare word giving the new tag |
| ld_rpa | input | 32 | Physical word giving page number and protection |

## Verification
The assertions take for granted that software never installs two entries with the same tag in one set. They also assume that lookup, load and invalidate inputs are known whenever reset is released. The bench follows both rules. It loads a translation only after a miss reports that translation absent, and it builds every compare word from its own model of the miss registers. It issues commands only at falling edges, so one lookup can meet a same-cycle load or invalidate only where a test aims at that case.

// File: rtl/itlb_swfill.sv
module itlb_swfill #(
  parameter int SETS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inv_all,
  input  logic [31:0] pt_base,
  input  logic        lk_valid,
  input  logic [31:0] lk_ea,
  input  logic [23:0] lk_vsid,
  output logic        lk_hit,
  output logic        lk_stall,
  output logic [19:0] lk_ppn,
  output logic [1:0]  lk_pp,
  output logic        miss_pend,
  output logic        miss_irq,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic        ld_valid,
  input  logic [31:0] ld_rb,
  input  logic [31:0] ld_cmp,
  input  logic [31:0] ld_rpa
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int PG_LO  = 12;
  localparam int TLO    = PG_LO + IDX_W;
  localparam int TAG_W  = 24 + 28 - TLO;
  localparam int HASH_W = 19;

  logic [SETS-1:0]  vld [2];
  logic [TAG_W-1:0] tag_m [2][SETS];
  logic [19:0]      ppn_m [2][SETS];
  logic [1:0]       pp_m  [2][SETS];
  logic [SETS-1:0]  lru;
  logic             pend_q, irq_q;
  logic [31:0]      imiss_q, icmp_q, hash1_q, hash2_q;

  wire [IDX_W-1:0] lk_set = lk_ea[PG_LO +: IDX_W];
  wire [TAG_W-1:0] lk_tag = {lk_vsid, lk_ea[27:TLO]};
  logic [1:0] way_hit;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign way_hit[w] = vld[w][lk_set] && (tag_m[w][lk_set] == lk_tag);
  end

  assign lk_hit   = lk_valid && !pend_q && |way_hit;
  assign lk_stall = lk_valid && !lk_hit;
  assign lk_ppn   = way_hit[1] ? ppn_m[1][lk_set] : ppn_m[0][lk_set];
  assign lk_pp    = way_hit[1] ? pp_m[1][lk_set]  : pp_m[0][lk_set];
  assign miss_pend = pend_q;
  assign miss_irq  = irq_q;

  wire miss_now = lk_valid && !pend_q && !(|way_hit) && !ld_valid && !inv_all;
  wire [HASH_W-1:0] hash = lk_vsid[HASH_W-1:0] ^ {3'b000, lk_ea[27:12]};

  wire [IDX_W-1:0] ld_set = ld_rb[PG_LO +: IDX_W];
  wire             ld_way = !vld[0][ld_set] ? 1'b0 : (!vld[1][ld_set] ? 1'b1 : lru[ld_set]);
  wire [TAG_W-1:0] ld_tag = {ld_cmp[30:7], ld_rb[27:TLO]};

  logic unused_bits;
  assign unused_bits = ^{ld_cmp[31], ld_cmp[6:0], ld_rpa[11:2], lk_ea[31:28], lk_ea[11:0],
                         ld_rb[31:28], ld_rb[11:0]};

  always_ff @(posedge clk) begin
    if (ld_valid) begin
      tag_m[ld_way][ld_set] <= ld_tag;
      ppn_m[ld_way][ld_set] <= ld_rpa[31:12];
      pp_m[ld_way][ld_set]  <= ld_rpa[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld[0]  <= '0;
      vld[1]  <= '0;
      lru     <= '0;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
      imiss_q <= '0;
      icmp_q  <= '0;
      hash1_q <= '0;
      hash2_q <= '0;
    end else begin
      irq_q <= miss_now;
      if (lk_hit) lru[lk_set] <= !way_hit[1];
      if (inv_all) begin
        vld[0] <= '0;
        vld[1] <= '0;
        pend_q <= 1'b0;
      end else if (ld_valid) begin
        vld[ld_way][ld_set] <= 1'b1;
        lru[ld_set]         <= !ld_way;
        pend_q              <= 1'b0;
      end else if (miss_now) begin
        pend_q  <= 1'b1;
        imiss_q <= lk_ea;
        icmp_q  <= {1'b1, lk_vsid, 1'b0, lk_ea[27:22]};
        hash1_q <= pt_base | {7'b0, hash, 6'b0};
        hash2_q <= pt_base | {7'b0, ~hash, 6'b0};
      end
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = imiss_q;
      2'd1:    rd_data = icmp_q;
      2'd2:    rd_data = hash1_q;
      default: rd_data = hash2_q;
    endcase
  end

  AST_MISS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_stall && !miss_pend && !ld_valid && !inv_all |=> miss_pend && miss_irq && imiss_q == $past(lk_ea)); // R2
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    miss_irq |=> !miss_irq); // R2
  AST_PEND_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_pend && lk_valid |-> lk_stall && !lk_hit); // R5
  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    miss_pend && !ld_valid && !inv_all |=> miss_pend && !miss_irq && $stable(imiss_q) && $stable(icmp_q)
      && $stable(hash1_q) && $stable(hash2_q)); // R5
  AST_LOAD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> !miss_pend); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !miss_pend && !lk_hit); // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !miss_pend && !miss_irq && !lk_hit); // R9
endmodule

// File: tb/itlb_swfill_tb.sv
module itlb_swfill_tb_top;
  logic clk = 0, rst_n = 0, inv_all = 0, lk_valid = 0, ld_valid = 0;
  logic [31:0] pt_base = 32'hA000_0000, lk_ea = 0, ld_rb = 0, ld_cmp = 0, ld_rpa = 0, rd_data;
  logic [23:0] lk_vsid = 0;
  logic [1:0]  rd_sel = 0, lk_pp;
  logic [19:0] lk_ppn;
  logic lk_hit, lk_stall, miss_pend, miss_irq;
  int tests = 0, fails = 0;
  logic r_hit, r_stall;
  logic [19:0] r_ppn;
  logic [1:0]  r_pp;

  always #5 clk = ~clk;

  itlb_swfill dut_i (.*);

  localparam logic [31:0] EA_A = 32'h0123_4000, EA_B = 32'h0563_4000, EA_C = 32'h0AB9_4000,
                          EA_D = 32'h0000_5000, EA_E = 32'h0777_7000, EA_F = 32'h0888_8000;
  localparam logic [23:0] V1 = 24'h012345, V2 = 24'h0ABCDE, V3 = 24'h123456;
  localparam int NV = 12;
  localparam logic [76:0] VEC [NV] = '{
    {EA_A, V1, 20'h11111, 1'b0}, {EA_B, V1, 20'h22222, 1'b0}, {EA_A, V1, 20'h11111, 1'b1},
    {EA_C, V1, 20'h33333, 1'b0}, {EA_A, V1, 20'h11111, 1'b1}, {EA_B, V1, 20'h22222, 1'b0},
    {EA_C, V1, 20'h33333, 1'b0}, {EA_B, V1, 20'h22222, 1'b1}, {EA_A, V1, 20'h11111, 1'b0},
    {EA_D, V2, 20'h44444, 1'b0}, {EA_D, V3, 20'h55555, 1'b0}, {EA_D, V2, 20'h44444, 1'b1}};

  function automatic logic [31:0] m_icmp(input logic [31:0] ea, input logic [23:0] v);
    return {1'b1, v, 1'b0, ea[27:22]};
  endfunction
  function automatic logic [18:0] m_hash(input logic [31:0] ea, input logic [23:0] v);
    return v[18:0] ^ {3'b000, ea[27:12]};
  endfunction
  function automatic logic [31:0] m_rpa(input logic [19:0] p);
    return {p, 10'b0, p[1:0]};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] ea, input logic [23:0] v);
    @(negedge clk); lk_valid = 1; lk_ea = ea; lk_vsid = v;
    #1; r_hit = lk_hit; r_stall = lk_stall; r_ppn = lk_ppn; r_pp = lk_pp;
    @(negedge clk); lk_valid = 0; #1;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    rd_sel = s; #1; d = rd_data;
  endtask

  task automatic load(input logic [31:0] rb, input logic [31:0] cmp, input logic [31:0] rpa);
    @(negedge clk); ld_valid = 1; ld_rb = rb; ld_cmp = cmp; ld_rpa = rpa;
    @(negedge clk); ld_valid = 0; #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [18:0] h;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk("R9", "miss_pend", {31'b0, miss_pend}, 0);
    chk("R9", "miss_irq", {31'b0, miss_irq}, 0);
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], d); chk("R9", "miss register", d, 0);
    end

    for (int i = 0; i < NV; i++) begin
      logic [31:0] ea; logic [23:0] v; logic [19:0] p; logic eh;
      {ea, v, p, eh} = VEC[i];
      lookup(ea, v);
      chk("R1 R7", "hit", {31'b0, r_hit}, {31'b0, eh});
      if (eh) begin
        chk("R1", "ppn", {12'b0, r_ppn}, {12'b0, p});
        chk("R1", "pp", {30'b0, r_pp}, {30'b0, p[1:0]});
      end else begin
        chk("R2", "stall", {31'b0, r_stall}, 1);
        chk("R2", "irq", {31'b0, miss_irq}, 1);
        chk("R2", "pend", {31'b0, miss_pend}, 1);
        h = m_hash(ea, v);
        rd(0, d); chk("R2", "imiss", d, ea);
        rd(1, d); chk("R3", "icmp", d, m_icmp(ea, v));
        rd(2, d); chk("R4", "hash1", d, pt_base | {7'b0, h, 6'b0});
        rd(3, d); chk("R4", "hash2", d, pt_base | {7'b0, ~h, 6'b0});
        @(negedge clk); #1;
        chk("R2", "irq one cycle", {31'b0, miss_irq}, 0);
        load(ea, m_icmp(ea, v), m_rpa(p));
        chk("R6", "pend cleared", {31'b0, miss_pend}, 0);
        lookup(ea, v);
        chk("R6", "retry hit", {31'b0, r_hit}, 1);
        chk("R6", "retry ppn", {12'b0, r_ppn}, {12'b0, p});
      end
    end

    lookup(EA_E, V1);
    chk("R5", "miss on E", {31'b0, miss_pend}, 1);
    lookup(EA_A, V1);
    chk("R5", "resident blocked hit", {31'b0, r_hit}, 0);
    chk("R5", "resident stalls", {31'b0, r_stall}, 1);
    lookup(EA_F, V2);
    chk("R5", "no second irq", {31'b0, miss_irq}, 0);
    rd(0, d); chk("R5", "imiss held", d, EA_E);
    rd(1, d); chk("R5", "icmp held", d, m_icmp(EA_E, V1));

    @(negedge clk); inv_all = 1; ld_valid = 1; ld_rb = EA_E; ld_cmp = m_icmp(EA_E, V1); ld_rpa = m_rpa(20'h66666);
    @(negedge clk); inv_all = 0; ld_valid = 0; #1;
    chk("R8", "pend dropped", {31'b0, miss_pend}, 0);
    lookup(EA_A, V1);
    chk("R8", "A gone", {31'b0, r_hit}, 0);
    rd(0, d); chk("R8", "imiss A", d, EA_A);
    load(EA_A, m_icmp(EA_A, V1), m_rpa(20'h11111));
    lookup(EA_E, V1);
    chk("R8", "load during invalidate dropped", {31'b0, r_hit}, 0);
    load(EA_E, m_icmp(EA_E, V1), m_rpa(20'h66666));
    lookup(EA_E, V1);
    chk("R6", "E hit", {31'b0, r_hit}, 1);
    chk("R6", "E ppn", {12'b0, r_ppn}, 32'h66666);
    lookup(EA_A, V1);
    chk("R7", "A refilled after invalidate", {12'b0, r_ppn}, 32'h11111);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule